// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes from a host into start/stop framed characters on a single serial line. The host sees two things: a holding register and an empty flag. It loads the holding register while the flag reads 1. It then clears the flag to ask for transmission. An internal shift register takes the byte from the holding register and sets the flag again, so the host can stage the next byte while the current one is still on the line. The shift register has no host access.

Bit timing comes from a one-cycle `bit_tick` pulse supplied by an external rate divider. Each transmitted bit lasts exactly one tick period. Four mode inputs pick the frame shape:

- 7 or 8 data bits
- parity on or off
- odd or even parity
- one or two stop bits

The block samples these inputs at the moment a byte moves into the shift register.

The shifter is a named state machine with the states `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_STOP1` and `ST_STOP2`. Its transitions all happen on a clock edge where `bit_tick` is 1:

- **load**: `ST_IDLE` or the final stop state goes to `ST_START` when a transfer is requested.
- **begin data**: `ST_START` goes to `ST_DATA`.
- **data done**: `ST_DATA` goes to `ST_PARITY` or `ST_STOP1` after the last data bit.
- **parity done**: `ST_PARITY` goes to `ST_STOP1`.
- **second stop**: `ST_STOP1` goes to `ST_STOP2` when two stop bits are selected.
- **finish**: the final stop state goes to `ST_IDLE` when no request is waiting.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1 (the idle level), `tx_empty` is 1, and the line stays at 1 while nothing is queued.
- R2: A write on `hold_wr` updates the holding register only while `tx_empty` is 1. A write made while it is 0 is ignored, and the frame that is then sent carries the earlier byte.
- R3: With `tx_empty` at 1, asserting `flag_clr` drives `tx_empty` to 0 after the next clock edge. The flag returns to 1 only at the edge where the byte moves into the shift register. `flag_clr` while the flag is 0 has no effect.
- R4: The transfer happens on a `bit_tick` edge while the shifter is idle or is in its final stop bit. From that edge the line shows one start bit at 0 for one tick period.
- R5: The data bits follow the start bit, least significant bit first, one per tick period. There are 8 bits when `mode_short` is 0. When `mode_short` is 1 there are 7 bits and bit 7 of the byte is never sent.
- R6: With `mode_parity` at 1, one parity bit follows the data. The parity bit is computed over only the configured data bits. With `mode_odd` at 0, the count of ones in data plus parity is even. With `mode_odd` at 1, that count is odd.
- R7: The frame ends with one stop bit at 1, or with two when `mode_two_stop` is 1.
- R8: If a transfer is pending when the final stop bit ends, the next start bit follows on the very next tick period, with no idle gap.
- R9: The mode inputs are sampled at the transfer edge. Changing them while a frame is shifting does not alter that frame.
- R10: `tx_line` changes only in the cycle that follows a clock edge at which `bit_tick` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit period |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | DATA_W | Byte to write into the holding register |
| flag_clr | input | 1 | Clears the empty flag to request transmission |
| mode_short | input | 1 | 1 selects DATA_W-1 data bits, 0 selects DATA_W |
| mode_parity | input | 1 | 1 appends a parity bit |
| mode_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| mode_two_stop | input | 1 | 1 selects two stop bits |
| tx_empty | output | 1 | Empty flag: 1 means the holding register may be written |
| tx_line | output | 1 | Serial output line |

## Verification
The bench builds the block with its default `DATA_W` of 8. It runs with two tick rates:

- **A tick every fourth cycle.** This leaves room between bit boundaries, so any line movement off a tick can be seen. It also leaves the flag sitting at 0 for several cycles before a load.
- **A tick on every cycle.** This drives the shifter at full rate. At this rate the load, the back-to-back start bit and the flag's return all crowd into adjacent edges.

Across both rates the bench covers all four frame shapes. It also exercises ignored writes and clears while the flag is 0, mode changes in the middle of a frame, and a second byte queued behind a frame that is still shifting.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } txs_state_e;

    typedef struct packed {
        logic short_len;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } txs_mode_t;

endpackage

// File: rtl/txs_hold.sv
module txs_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_req,
    input  logic              load_ack,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty
);

    logic [DATA_W-1:0] hold_q;
    logic              empty_q;

    // The holding register takes a write only while the flag reads empty.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en && empty_q) begin
            hold_q <= wr_data;
        end
    end

    // A host clear drops the flag; completing the transfer raises it again.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (empty_q && clr_req) begin
            empty_q <= 1'b0;
        end else if (load_ack) begin
            empty_q <= 1'b1;
        end
    end

    assign hold_data = hold_q;
    assign empty     = empty_q;

endmodule

// File: rtl/txs_parity.sv
module txs_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              short_len,
    input  logic              odd,
    output logic              par_bit
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] masked;

    // In short mode the top data bit is dropped from the parity count.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_mask
            if (gi == DATA_W - 1) begin : g_top
                assign mask[gi] = ~short_len;
            end else begin : g_low
                assign mask[gi] = 1'b1;
            end
        end
    endgenerate

    assign masked  = data & mask;
    assign par_bit = (^masked) ^ odd;

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
    import txs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              req,
    input  logic [DATA_W-1:0] hold_data,
    input  txs_mode_t         mode_in,
    input  logic              par_in,
    output logic              load_ack,
    output logic              tx_line
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(DATA_W - 2);

    txs_state_e        state_q, state_d;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              par_en_q;
    logic              two_stop_q;
    logic              par_q;
    logic              can_load;

    // The shifter can take a new byte on a tick while idle or at the end of its final stop bit.
    always_comb begin
        can_load = 1'b0;
        if (bit_tick) begin
            unique case (state_q)
                ST_IDLE:  can_load = 1'b1;
                ST_STOP1: can_load = ~two_stop_q;
                ST_STOP2: can_load = 1'b1;
                default:  can_load = 1'b0;
            endcase
        end
    end

    assign load_ack = can_load && req;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ack) state_d = ST_START;
            end
            ST_START: begin
                if (bit_tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_tick && cnt_q == '0)
                    state_d = par_en_q ? ST_PARITY : ST_STOP1;
            end
            ST_PARITY: begin
                if (bit_tick) state_d = ST_STOP1;
            end
            ST_STOP1: begin
                if (bit_tick) begin
                    if (two_stop_q) state_d = ST_STOP2;
                    else            state_d = req ? ST_START : ST_IDLE;
                end
            end
            ST_STOP2: begin
                if (bit_tick) state_d = req ? ST_START : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift datapath; the frame settings are latched at load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
            par_q      <= 1'b0;
        end else if (load_ack) begin
            sh_q       <= hold_data;
            cnt_q      <= mode_in.short_len ? CNT_SHORT : CNT_LONG;
            par_en_q   <= mode_in.par_en;
            two_stop_q <= mode_in.two_stop;
            par_q      <= par_in;
        end else if (state_q == ST_DATA && bit_tick && cnt_q != '0) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_IDLE:   tx_line = 1'b1;
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = sh_q[0];
            ST_PARITY: tx_line = par_q;
            ST_STOP1:  tx_line = 1'b1;
            ST_STOP2:  tx_line = 1'b1;
            default:   tx_line = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import txs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              flag_clr,
    input  logic              mode_short,
    input  logic              mode_parity,
    input  logic              mode_odd,
    input  logic              mode_two_stop,
    output logic              tx_empty,
    output logic              tx_line
);

    logic [DATA_W-1:0] hold_data;
    logic              empty;
    logic              load_ack;
    logic              par_bit;
    txs_mode_t         mode;

    assign mode = '{short_len: mode_short, par_en: mode_parity,
                    par_odd: mode_odd, two_stop: mode_two_stop};

    txs_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hold_wr),
        .wr_data   (hold_wdata),
        .clr_req   (flag_clr),
        .load_ack  (load_ack),
        .hold_data (hold_data),
        .empty     (empty)
    );

    txs_parity #(.DATA_W(DATA_W)) u_par (
        .data      (hold_data),
        .short_len (mode.short_len),
        .odd       (mode.par_odd),
        .par_bit   (par_bit)
    );

    txs_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .req       (~empty),
        .hold_data (hold_data),
        .mode_in   (mode),
        .par_in    (par_bit),
        .load_ack  (load_ack),
        .tx_line   (tx_line)
    );

    assign tx_empty = empty;

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic flag_clr,
    input logic tx_empty,
    input logic tx_line
);

    // R10: the line moves only after a tick edge
    p_line_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(tx_line));

    // R3: a clear on a set flag drops it
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && flag_clr |=> !tx_empty);

    // R3: the flag rises only on a tick edge (the transfer)
    p_no_rise_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_empty && !bit_tick |=> !tx_empty);

    // R3: the flag never drops without a clear
    p_no_drop_without_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && !flag_clr |=> tx_empty);

    // R4: the transfer edge puts the start bit on the line
    p_start_follows_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> !tx_line);

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .flag_clr (flag_clr),
    .tx_empty (tx_empty),
    .tx_line  (tx_line)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          hold_wr = 1'b0;
    logic [DW-1:0] hold_wdata = '0;
    logic          flag_clr = 1'b0;
    logic          mode_short = 1'b0;
    logic          mode_parity = 1'b0;
    logic          mode_odd = 1'b0;
    logic          mode_two_stop = 1'b0;
    logic          tx_empty;
    logic          tx_line;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int tick_div = 4;
    int tcnt = 0;
    bit done = 0;

    // Behavioural reference: queue of bits still to appear on the line
    bit            mq[$];
    bit            mflag = 1;
    logic [DW-1:0] mhold = '0;
    bit            last_tick = 0;
    logic          prev_tx = 1'b1;

    always #10 clk = ~clk;

    serial_frame_tx #(.DATA_W(DW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .hold_wr       (hold_wr),
        .hold_wdata    (hold_wdata),
        .flag_clr      (flag_clr),
        .mode_short    (mode_short),
        .mode_parity   (mode_parity),
        .mode_odd      (mode_odd),
        .mode_two_stop (mode_two_stop),
        .tx_empty      (tx_empty),
        .tx_line       (tx_line)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Tick generator
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt = 0;
            bit_tick = 1'b0;
        end else begin
            tcnt++;
            if (tcnt >= tick_div) begin
                tcnt = 0;
                bit_tick = 1'b1;
            end else begin
                bit_tick = 1'b0;
            end
        end
    end

    // Reference model update
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            mflag = 1;
            mhold = '0;
            last_tick = 0;
        end else begin
            bit ld;
            bit nf;
            ld = bit_tick && (mq.size() <= 1) && !mflag;
            nf = mflag;
            if (mflag && flag_clr) nf = 0;
            else if (ld) nf = 1;
            if (hold_wr && mflag) mhold = hold_wdata;
            if (bit_tick && mq.size() > 0) void'(mq.pop_front());
            if (ld) begin
                int len;
                bit p;
                len = mode_short ? DW - 1 : DW;
                p = mode_odd;
                mq.push_back(1'b0);
                for (int i = 0; i < len; i++) begin
                    mq.push_back(mhold[i]);
                    p = p ^ mhold[i];
                end
                if (mode_parity) mq.push_back(p);
                mq.push_back(1'b1);
                if (mode_two_stop) mq.push_back(1'b1);
            end
            mflag = nf;
            last_tick = bit_tick;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            bit exp_line;
            exp_line = (mq.size() > 0) ? mq[0] : 1'b1;
            chk(tx_line === exp_line, "R2/R4/R5/R6/R7/R8/R9 line", int'(tx_line), int'(exp_line));
            chk(tx_empty === mflag, "R3 flag", int'(tx_empty), int'(mflag));
            if (!last_tick)
                chk(tx_line === prev_tx, "R10 steady", int'(tx_line), int'(prev_tx));
            prev_tx = tx_line;
        end
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            report();
        end
    end

    task automatic set_mode(input bit s, input bit pe, input bit od, input bit ts);
        mode_short = s;
        mode_parity = pe;
        mode_odd = od;
        mode_two_stop = ts;
    endtask

    task automatic wait_empty();
        while (tx_empty !== 1'b1) @(negedge clk);
    endtask

    task automatic send(input logic [DW-1:0] d);
        wait_empty();
        hold_wr = 1'b1;
        hold_wdata = d;
        @(negedge clk);
        hold_wr = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(tx_empty === 1'b0, "R3 clear", int'(tx_empty), 0);
    endtask

    task automatic drain();
        while (!(mq.size() == 0 && mflag)) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(tx_line === 1'b1, "R1 idle", int'(tx_line), 1);
    endtask

    task automatic run_set();
        // R5 R7: 8 data bits, no parity, one stop
        set_mode(0, 0, 0, 0); send(8'hA5); drain();
        // R5 R6: 7 data bits with even parity, bit 7 set but unsent
        set_mode(1, 1, 0, 0); send(8'hC3); drain();
        // R6 R7: 8 bits, odd parity, two stops
        set_mode(0, 1, 1, 1); send(8'h5E); drain();
        // R6: 7 bits odd parity, bit 7 only difference
        set_mode(1, 1, 1, 1); send(8'h81); drain();
        // R9: change mode inputs while the frame shifts
        set_mode(0, 1, 0, 1); send(8'h3C);
        repeat (5) @(negedge clk);
        set_mode(1, 0, 1, 0);
        drain();
        // R8 R2: queue a second byte behind a shifting frame, then try to overwrite it
        set_mode(0, 1, 0, 0); send(8'h96);
        send(8'h0F);
        hold_wr = 1'b1;
        hold_wdata = 8'hFF;
        flag_clr = 1'b1;
        @(negedge clk);
        hold_wr = 1'b0;
        flag_clr = 1'b0;
        chk(tx_empty === 1'b0, "R2 ignored clear", int'(tx_empty), 0);
        drain();
        // R8 with two stop bits
        set_mode(1, 0, 0, 1); send(8'h71); send(8'h2A); drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_line === 1'b1, "R1 reset line", int'(tx_line), 1);
        chk(tx_empty === 1'b1, "R1 reset flag", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(tx_line === 1'b1, "R1 idle line", int'(tx_line), 1);
        tick_div = 4;
        run_set();
        tick_div = 1;
        run_set();
        report();
    end

endmodule